// File: doc/BRIEF.md
# NAND Flash Bus Interface Sequencer

This block stands between a host and an 8-bit NAND flash device. The device has one multiplexed I/O port. Command bytes, address bytes and data bytes all travel over the same eight wires. The device tells them apart only by two latch lines, one for commands and one for addresses. The host hands the sequencer one operation at a time over a valid/ready handshake. Each operation carries a 3-bit opcode and, for writes, a byte. The sequencer turns it into the matching pattern on chip enable, the two latch lines, the read and write strobes and the data-bus output enable. When the operation is over, it raises a one-cycle done pulse, together with the captured byte for a read.

Every phase of a byte access lasts a number of system clock cycles set by a parameter: setup, strobe low, recovery after a read, and data hold after a write. A wait operation covers the device's busy periods in one of two ways. When the ready/busy pin is wired (`USE_RB`=1), the sequencer synchronises the pin and polls it after a short guard window. When the pin is not wired, it counts a fixed delay, which by default is 20 us at 250 MHz.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset and whenever no operation is in progress, the pins are parked: `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, `nand_cle`, `nand_ale` and `nand_io_oe` are low, `req_ready` is high and `rsp_done` is low.
- R2: The latch lines follow the opcode and stay constant for the whole access.
  - Opcode 0 (command write) holds `nand_cle` high.
  - Opcode 1 (address write) holds `nand_ale` high.
  - Opcode 2 (data write) and opcode 3 (data read) keep both latch lines low.
  - The two latch lines are never high together.
- R3: `nand_ce_n` is low for every cycle of a byte access and of a wait. A strobe is never low while `nand_ce_n` is high.
- R4: A write-type access (opcodes 0, 1, 2) has three phases: `T_SETUP` cycles with strobes high, then `nand_we_n` low for exactly `T_LOW` cycles, then `T_HOLD` cycles. `rsp_done` is high in the cycle that follows these phases.
- R5: During a write-type access, `nand_io_oe` is high for every cycle and `nand_io_out` carries the host byte. During a read (opcode 3), `nand_io_oe` stays low, so it is never high while `nand_re_n` is low.
- R6: Write data stays driven and unchanged for `T_HOLD` cycles after `nand_we_n` rises.
- R7: A read has three phases: `T_SETUP` cycles, then `nand_re_n` low for `T_LOW` cycles, then `T_HIGH` recovery cycles. The value on `nand_io_in` in the last strobe-low cycle appears on `rsp_rdata` with `rsp_done`.
- R8: `req_ready` is low from the cycle after a byte access or a wait is accepted until `rsp_done` is raised.
- R9: With `USE_RB`=1, a wait (opcode 4) ignores `nand_rb` for `T_WB` cycles. After that, it completes on the third clock edge after `nand_rb` rises, because of a two-stage synchroniser plus one poll cycle. If `nand_rb` is already high, it completes `T_WB`+1 cycles after acceptance.
- R10: With `USE_RB`=0, a wait completes exactly `BUSY_CYC` cycles after acceptance, whatever `nand_rb` does.
- R11: `rsp_done` is a single-cycle pulse.
- R12: Opcodes 5 to 7 finish in the cycle right after acceptance and cause no pin activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host presents an operation |
| req_ready | output | 1 | Sequencer is idle and accepts an operation |
| req_op | input | 3 | Opcode: 0 command, 1 address, 2 data write, 3 data read, 4 wait |
| req_wdata | input | DATA_W | Byte for write-type operations |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Byte captured by the last read |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | DATA_W | Data driven toward the device |
| nand_io_oe | output | 1 | Output enable for the shared I/O bus |
| nand_io_in | input | DATA_W | Data returned by the device |
| nand_rb | input | 1 | Ready/busy, low while busy |

## Verification
Let the cycle in which the accepting clock edge occurs be cycle 0. Every pin then changes at a fixed cycle:
- The write or read strobe falls `T_SETUP` cycles after acceptance.
- The done pulse comes `T_SETUP`+`T_LOW`+`T_HOLD` (or `T_HIGH`) cycles after acceptance.
- A pinless wait ends after `BUSY_CYC` cycles.
- A pin-polled wait ends on the third edge after the busy pin rises.

The bench samples every output on the falling clock edge and keeps a cycle index from acceptance. It compares the index at which each event appears, and the number of cycles each pin spends asserted, against those sums. It never waits for an event to appear.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    typedef enum logic [2:0] {
        OP_CMD   = 3'd0,
        OP_ADDR  = 3'd1,
        OP_WDATA = 3'd2,
        OP_RDATA = 3'd3,
        OP_WAIT  = 3'd4
    } nbs_op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_RECOV,
        PH_GUARD,
        PH_POLL
    } nbs_phase_e;

    typedef struct packed {
        logic ce_n;
        logic cle;
        logic ale;
        logic we_n;
        logic re_n;
        logic oe;
    } nbs_pins_t;

    localparam nbs_pins_t PINS_PARKED = '{ce_n: 1'b1, cle: 1'b0, ale: 1'b0,
                                          we_n: 1'b1, re_n: 1'b1, oe: 1'b0};

    function automatic logic op_is_write(input logic [2:0] op);
        return (op == OP_CMD) || (op == OP_ADDR) || (op == OP_WDATA);
    endfunction

    function automatic logic op_is_byte(input logic [2:0] op);
        return op_is_write(op) || (op == OP_RDATA);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nbs_cycle_timer.sv
module nbs_cycle_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/nbs_rb_sync.sv
module nbs_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rb_raw,
    output logic rb_ready
);
    logic [STAGES-1:0] sh;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sh[0] <= 1'b0;
                    else     sh[0] <= rb_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sh[i] <= 1'b0;
                    else     sh[i] <= sh[i-1];
                end
            end
        end
    endgenerate

    assign rb_ready = sh[STAGES-1];
endmodule

// File: rtl/nbs_pin_map.sv
module nbs_pin_map
    import nbs_pkg::*;
(
    input  nbs_phase_e ph,
    input  logic [2:0] op,
    output nbs_pins_t  pins
);
    logic in_byte;
    logic wr;

    always_comb begin
        in_byte = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_RECOV);
        wr      = op_is_write(op);
        pins    = PINS_PARKED;
        if (ph != PH_IDLE) pins.ce_n = 1'b0;
        if (in_byte) begin
            pins.cle = (op == OP_CMD);
            pins.ale = (op == OP_ADDR);
            pins.oe  = wr;
        end
        if (ph == PH_STROBE) begin
            pins.we_n = ~wr;
            pins.re_n = ~(op == OP_RDATA);
        end
    end
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
    import nbs_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int T_SETUP  = 2,
    parameter int T_LOW    = 3,
    parameter int T_HIGH   = 2,
    parameter int T_HOLD   = 2,
    parameter int T_WB     = 25,
    parameter int BUSY_CYC = 5000,
    parameter int USE_RB   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DATA_W-1:0] nand_io_out,
    output logic              nand_io_oe,
    input  logic [DATA_W-1:0] nand_io_in,
    input  logic              nand_rb
);
    localparam int MAXV  = imax(imax(imax(T_SETUP, T_LOW), imax(T_HIGH, T_HOLD)),
                                imax(T_WB, BUSY_CYC));
    localparam int CW    = $clog2(MAXV + 1);
    localparam int WAITV = (USE_RB != 0) ? T_WB : BUSY_CYC;

    nbs_phase_e        ph;
    logic [2:0]        op_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] rd_q;
    logic              done_q;

    logic              t_load;
    logic [CW-1:0]     t_val;
    logic              t_zero;
    logic              rb_ok;
    nbs_pins_t         pins;

    nbs_cycle_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    nbs_rb_sync #(.STAGES(2)) u_rb (
        .clk(clk), .rst(rst), .rb_raw(nand_rb), .rb_ready(rb_ok)
    );

    nbs_pin_map u_pins (.ph(ph), .op(op_q), .pins(pins));

    // Timer reload at the entry of each timed phase.
    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        unique case (ph)
            PH_IDLE: if (req_valid) begin
                if (op_is_byte(req_op)) begin
                    t_load = 1'b1;
                    t_val  = CW'(T_SETUP - 1);
                end else if (req_op == OP_WAIT) begin
                    t_load = 1'b1;
                    t_val  = CW'(WAITV - 1);
                end
            end
            PH_SETUP: if (t_zero) begin
                t_load = 1'b1;
                t_val  = CW'(T_LOW - 1);
            end
            PH_STROBE: if (t_zero) begin
                t_load = 1'b1;
                t_val  = op_is_write(op_q) ? CW'(T_HOLD - 1) : CW'(T_HIGH - 1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            op_q   <= '0;
            wd_q   <= '0;
            rd_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (ph)
                PH_IDLE: if (req_valid) begin
                    op_q <= req_op;
                    wd_q <= req_wdata;
                    if (op_is_byte(req_op))      ph <= PH_SETUP;
                    else if (req_op == OP_WAIT)  ph <= PH_GUARD;
                    else                         done_q <= 1'b1;
                end
                PH_SETUP:  if (t_zero) ph <= PH_STROBE;
                PH_STROBE: if (t_zero) begin
                    if (op_q == OP_RDATA) rd_q <= nand_io_in;
                    ph <= PH_RECOV;
                end
                PH_RECOV: if (t_zero) begin
                    ph     <= PH_IDLE;
                    done_q <= 1'b1;
                end
                PH_GUARD: if (t_zero) begin
                    if (USE_RB != 0) begin
                        ph <= PH_POLL;
                    end else begin
                        ph     <= PH_IDLE;
                        done_q <= 1'b1;
                    end
                end
                PH_POLL: if (rb_ok) begin
                    ph     <= PH_IDLE;
                    done_q <= 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign req_ready   = (ph == PH_IDLE);
    assign rsp_done    = done_q;
    assign rsp_rdata   = rd_q;
    assign nand_ce_n   = pins.ce_n;
    assign nand_cle    = pins.cle;
    assign nand_ale    = pins.ale;
    assign nand_we_n   = pins.we_n;
    assign nand_re_n   = pins.re_n;
    assign nand_io_oe  = pins.oe;
    assign nand_io_out = wd_q;
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
    parameter int DATA_W = 8,
    parameter int T_LOW  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              nand_ce_n,
    input logic              nand_cle,
    input logic              nand_ale,
    input logic              nand_we_n,
    input logic              nand_re_n,
    input logic              nand_io_oe,
    input logic [DATA_W-1:0] nand_io_out
);
    logic [15:0] we_run;

    always_ff @(posedge clk) begin
        if (rst || nand_we_n) we_run <= '0;
        else                  we_run <= we_run + 1'b1;
    end

    p_parked_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_io_oe && !nand_cle && !nand_ale));

    p_latch_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    p_latch_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (!nand_ce_n && $past(!nand_ce_n) && $past(!req_ready)) |-> ($stable(nand_cle) && $stable(nand_ale)));

    p_strobe_ce_r3: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    p_strobe_width_r4: assert property (@(posedge clk) disable iff (rst)
        !nand_we_n |-> (we_run < 16'(T_LOW)));

    p_no_fight_r5: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> !nand_io_oe);

    p_drive_on_write_r5: assert property (@(posedge clk) disable iff (rst)
        !nand_we_n |-> nand_io_oe);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_we_n) |-> (nand_io_oe && $stable(nand_io_out)));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);
endmodule

bind nand_bus_seq nbs_checker #(.DATA_W(DATA_W), .T_LOW(T_LOW)) u_nbs_checker (
    .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_done(rsp_done),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_oe(nand_io_oe),
    .nand_io_out(nand_io_out)
);

// File: tb/tb_nand_bus_seq.sv
`timescale 1ns/1ps
module tb_nand_bus_seq;
    localparam int TS = 2, TL = 3, THI = 2, THO = 2, TWB = 3, BUSY = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic [7:0] req_wdata = 8'h00;
    logic [7:0] rd_val = 8'h00;
    logic       rb = 1'b1;

    logic       ready, done, ce_n, cle, ale, we_n, re_n, oe;
    logic [7:0] rdata, io_out, io_in;
    logic       ready_b, done_b, ce_n_b, cle_b, ale_b, we_n_b, re_n_b, oe_b;
    logic [7:0] rdata_b, io_out_b, io_in_b;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign io_in   = !re_n   ? rd_val : 8'h00;
    assign io_in_b = !re_n_b ? rd_val : 8'h00;

    nand_bus_seq #(.T_SETUP(TS), .T_LOW(TL), .T_HIGH(THI), .T_HOLD(THO),
                   .T_WB(TWB), .BUSY_CYC(BUSY), .USE_RB(1)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(ready),
        .req_op(req_op), .req_wdata(req_wdata), .rsp_done(done), .rsp_rdata(rdata),
        .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n),
        .nand_re_n(re_n), .nand_io_out(io_out), .nand_io_oe(oe),
        .nand_io_in(io_in), .nand_rb(rb));

    nand_bus_seq #(.T_SETUP(TS), .T_LOW(TL), .T_HIGH(THI), .T_HOLD(THO),
                   .T_WB(TWB), .BUSY_CYC(BUSY), .USE_RB(0)) dut_nr (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(ready_b),
        .req_op(req_op), .req_wdata(req_wdata), .rsp_done(done_b), .rsp_rdata(rdata_b),
        .nand_ce_n(ce_n_b), .nand_cle(cle_b), .nand_ale(ale_b), .nand_we_n(we_n_b),
        .nand_re_n(re_n_b), .nand_io_out(io_out_b), .nand_io_oe(oe_b),
        .nand_io_in(io_in_b), .nand_rb(rb));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Accept on the next rising edge. Sample index n counts rising edges
    // after the accepting one; n=0 is the falling edge right after acceptance.
    task automatic run_byte(input logic [2:0] op, input logic [7:0] d, input logic [7:0] rv);
        int we_low = 0, re_low = 0, ce_low = 0, oe_cnt = 0, cle_cnt = 0, ale_cnt = 0;
        int bad_data = 0, first_str = -1, rdy_low = 0, done_n = -1, done_bn = -1;
        bit is_wr = (op <= 3'd2);
        rd_val = rv;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_wdata = d;
        @(posedge clk);
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (!we_n) begin we_low++; if (io_out != d) bad_data++; end
            if (!re_n) re_low++;
            if ((!we_n || !re_n) && first_str < 0) first_str = n;
            if (!ce_n) ce_low++;
            if (oe) oe_cnt++;
            if (cle) cle_cnt++;
            if (ale) ale_cnt++;
            if (!ready) rdy_low++;
            if (done_b && done_bn < 0) done_bn = n;
            if (done) begin done_n = n; break; end
        end
        if (is_wr) begin
            chk("R4 write done cycle", done_n, TS + TL + THO);
            chk("R4 write strobe start", first_str, TS);
            chk("R4 we_n low width", we_low, TL);
            chk("R5 oe cycles", oe_cnt, TS + TL + THO);
            chk("R5 data on bus", bad_data, 0);
            chk("R6 hold cycles", oe_cnt - TS - TL, THO);
            chk("R2 cle cycles", cle_cnt, (op == 3'd0) ? TS + TL + THO : 0);
            chk("R2 ale cycles", ale_cnt, (op == 3'd1) ? TS + TL + THO : 0);
            chk("R3 ce low cycles", ce_low, TS + TL + THO);
            chk("R8 ready low cycles", rdy_low, TS + TL + THO);
        end else if (op == 3'd3) begin
            chk("R7 read done cycle", done_n, TS + TL + THI);
            chk("R7 read strobe start", first_str, TS);
            chk("R7 re_n low width", re_low, TL);
            chk("R7 read data", int'(rdata), int'(rv));
            chk("R7 read data pinless variant", int'(rdata_b), int'(rv));
            chk("R5 no drive on read", oe_cnt, 0);
            chk("R2 no latch on read", cle_cnt + ale_cnt, 0);
            chk("R3 ce low cycles read", ce_low, TS + TL + THI);
        end else begin
            chk("R12 unknown op done cycle", done_n, 0);
            chk("R12 no pin activity", ce_low + we_low + re_low + oe_cnt, 0);
        end
        chk("R11 variants agree on done", done_bn, done_n);
        @(negedge clk);
        chk("R11 done single pulse", int'(done), 0);
        chk("R1 parked after op", int'(ce_n && we_n && re_n && !oe && ready), 1);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        logic [7:0] pats [6];
        int d1, d2, ce_w;
        pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ce_n", int'(ce_n), 1);
        chk("R1 strobes", int'(we_n && re_n), 1);
        chk("R1 latches and oe", int'(cle || ale || oe), 0);
        chk("R1 ready", int'(ready), 1);
        chk("R1 done", int'(done), 0);

        for (int op = 0; op < 3; op++)
            for (int k = 0; k < 6; k++)
                run_byte(3'(op), pats[k], 8'h00);
        for (int k = 0; k < 6; k++)
            run_byte(3'd3, 8'h00, ~pats[k] ^ 8'h3C);
        for (int op = 5; op < 8; op++)
            run_byte(3'(op), 8'h77, 8'h00);

        // R9/R10: wait with busy pin already high
        rb = 1'b1;
        repeat (4) @(negedge clk);
        req_valid = 1'b1; req_op = 3'd4;
        @(posedge clk);
        d1 = -1; d2 = -1; ce_w = 0;
        for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (done && d1 < 0) d1 = n;
            if (done_b && d2 < 0) d2 = n;
            if (!ce_n && d1 < 0) ce_w++;
        end
        chk("R9 wait with pin ready", d1, TWB + 1);
        chk("R10 pinless wait length", d2, BUSY);
        chk("R3 ce low during wait", ce_w, TWB + 1);

        // R9/R10: wait with busy pin low, released later
        rb = 1'b0;
        repeat (4) @(negedge clk);
        req_valid = 1'b1; req_op = 3'd4;
        @(posedge clk);
        d1 = -1; d2 = -1;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (done && d1 < 0) d1 = n;
            if (done_b && d2 < 0) d2 = n;
        end
        chk("R9 no completion while busy", d1, -1);
        chk("R8 ready low while busy", int'(ready), 0);
        chk("R10 pinless wait ignores busy pin", d2, BUSY);
        rb = 1'b1;
        d1 = -1;
        for (int k = 1; k < 10; k++) begin
            @(negedge clk);
            if (done && d1 < 0) d1 = k;
        end
        chk("R9 completion after pin rise", d1, 3);

        finished = 1;
        summary();
    end
endmodule